// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block turns four asynchronous external interrupt request pins into clean, gated request lines for the interrupt priority logic. Each pin is brought into the clock domain by a two-flop synchroniser. It is then either passed through as a level, with a choice of polarity, or watched for a rising or falling edge. An edge is caught in a sticky latch that software clears by writing a one to that pin's clear bit.

All configuration sits in one 32-bit control word that is written and read through a plain register port. The word holds four 2-bit sense fields, four per-pin enables, four write-one-to-clear bits, a master enable for the external pins, and a routing bit. The routing bit sends pin 0 either to a dedicated critical request output or to the ordinary request vector. The request outputs are combinational functions of registered state.

Top module: `xirq_conditioner`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the control word reads 0x00000000 and every request output is 0.
- R2: The sense field for pin n is at bits [23-2n:22-2n]. Code 00 is level active high and code 11 is level active low. In a level code the request follows the pin, inverted for 11, and it appears after the second rising clock edge that samples the new pin value. No latch is involved.
- R3: Writing 1 to bit 27, 26, 25 or 24 clears the latched request of pin 0, 1, 2 or 3 at that edge. Writing 0 to these bits leaves the latches unchanged, and bits 27:24 always read back 0.
- R4: Bit 12 is the master external enable. While it is 0 every request output is 0. Setting it again exposes latches that were held in the meantime.
- R5: The enable for pin 0 is bit 11, and for pins 1, 2 and 3 it is bits 10, 9 and 8. An enable of 0 forces that pin's request to 0 without altering its latch.
- R6: With bit 0 set, pin 0's request drives req_crit_o and req_o[0] stays 0. With bit 0 clear, it drives req_o[0] and req_crit_o stays 0.
- R7: Code 01 (rising edge) and code 10 (falling edge) set the pin's latch one cycle after the synchronised edge, which is three clock edges after the pin changes. The latch stays set until it is cleared, whatever the pin does afterwards.
- R8: Clearing one pin's latch leaves the latches of the other three pins unchanged.
- R9: Bits 23:16, 12:8 and 0 read back the value last written. All other bits read 0.
- R10: If a clear write and a new edge event for the same pin fall in the same cycle, the latch stays set, so no event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Asynchronous external request pins |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Control word read data |
| req_o | output | 4 | Gated requests on the normal path |
| req_crit_o | output | 1 | Gated pin 0 request on the critical path |

## Verification
The bench drives the pins with slow square waves under both level polarities, which tells inversion apart from pass-through and confirms the two-edge synchroniser delay. Single pulses under the rising and falling codes show that each edge mode latches only its own transition and holds after the pin returns. Clear writes aimed at one pin, clear writes with only zero clear bits, and a clear that lands in the same cycle as a fresh edge separate per-pin clearing from global clearing and from event loss. Master and per-pin enable toggles over live latches, followed by a long stretch of random pins and writes, compare against the reference model in every cycle.

// File: rtl/xirq_pkg.sv
// Package: shared constants and the sense code type for the external
// interrupt conditioner. The bit positions are fixed by the control word
// layout, which software relies on.
package xirq_pkg;
    localparam int NUM_PINS   = 4;
    localparam int CTRL_W     = 32;
    localparam int CLR_HI     = 27;   // clear bit of pin n is CLR_HI-n
    localparam int SENSE_HI   = 23;   // sense of pin n is [SENSE_HI-2n -: 2]
    localparam int MASTER_BIT = 12;
    localparam int EN_HI      = 11;   // enable of pin n is EN_HI-n
    localparam int ROUTE_BIT  = 0;
    localparam logic [CTRL_W-1:0] KEEP_MASK = 32'h00FF_1F01;

    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'b00,
        SENSE_RISE   = 2'b01,
        SENSE_FALL   = 2'b10,
        SENSE_LVL_LO = 2'b11
    } sense_e;
endpackage

// File: rtl/xirq_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes STAGES >= 2 and that each bit is independent (no bus coherency).
module xirq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/xirq_ctrl_reg.sv
// Module: the packed control word. Holds sense, enable, master and route
// fields; write-one-to-clear bits are not stored and only produce a pulse
// in the write cycle. Assumes a single write port with no byte strobes.
module xirq_ctrl_reg
    import xirq_pkg::*;
#(
    parameter int N = NUM_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic [2*N-1:0]    sense_o,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      clr_o,
    output logic              master_o,
    output logic              route_o
);
    logic [CTRL_W-1:0] ctrl_q;

    // Capture the storable fields of a write; everything else drops.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_data & KEEP_MASK;
    end

    // Unpack per-pin fields, reversing the descending bit order.
    genvar n;
    generate
        for (n = 0; n < N; n++) begin : g_fld
            assign sense_o[2*n +: 2] = ctrl_q[SENSE_HI-2*n -: 2];
            assign en_o[n]           = ctrl_q[EN_HI-n];
            assign clr_o[n]          = wr_en & wr_data[CLR_HI-n];
        end
    endgenerate

    assign master_o = ctrl_q[MASTER_BIT];
    assign route_o  = ctrl_q[ROUTE_BIT];
    assign rd_data  = ctrl_q;
endmodule

// File: rtl/xirq_pin_cond.sv
// Module: per-pin sense logic. Takes an already synchronised pin, detects
// the selected edge into a sticky latch, or passes the level through.
// Assumes sync_i is free of metastability. A new edge beats a clear.
module xirq_pin_cond
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [1:0] sense_i,
    input  logic       clr_i,
    output logic       active_o,
    output logic       edge_o,
    output logic       latch_o
);
    logic   prev_q;
    logic   latch_q;
    sense_e mode;

    assign mode = sense_e'(sense_i);

    // Remember the previous synchronised sample and update the latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= sync_i;
            latch_q <= edge_o | (latch_q & ~clr_i);
        end
    end

    // Select the edge of interest for the current sense code.
    always_comb begin
        unique case (mode)
            SENSE_RISE: edge_o = sync_i & ~prev_q;
            SENSE_FALL: edge_o = ~sync_i & prev_q;
            default:    edge_o = 1'b0;
        endcase
    end

    // Choose between the level path and the latched path.
    always_comb begin
        unique case (mode)
            SENSE_LVL_HI: active_o = sync_i;
            SENSE_LVL_LO: active_o = ~sync_i;
            default:      active_o = latch_q;
        endcase
    end

    assign latch_o = latch_q;
endmodule

// File: rtl/xirq_conditioner.sv
// Module: top of the external interrupt conditioner. Synchronises four pins,
// conditions each one, gates with per-pin and master enables and steers
// pin 0 to the critical or normal output. Outputs are combinational from
// registered state. Assumes a single clock domain for the register port.
module xirq_conditioner
    import xirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        pin_i,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       cfg_rd_data,
    output logic [3:0]        req_o,
    output logic              req_crit_o
);
    localparam int N = NUM_PINS;

    logic [N-1:0]   pin_sync;
    logic [2*N-1:0] ctrl_sense;
    logic [N-1:0]   ctrl_en;
    logic [N-1:0]   ctrl_clr;
    logic           ctrl_master;
    logic           ctrl_route;
    logic [N-1:0]   pin_active;
    logic [N-1:0]   pin_edge;
    logic [N-1:0]   pin_latch;
    logic [N-1:0]   gated;

    xirq_sync #(.WIDTH(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_i),
        .dout  (pin_sync)
    );

    xirq_ctrl_reg #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .rd_data  (cfg_rd_data),
        .sense_o  (ctrl_sense),
        .en_o     (ctrl_en),
        .clr_o    (ctrl_clr),
        .master_o (ctrl_master),
        .route_o  (ctrl_route)
    );

    genvar n;
    generate
        for (n = 0; n < N; n++) begin : g_pin
            xirq_pin_cond u_pin (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_i   (pin_sync[n]),
                .sense_i  (ctrl_sense[2*n +: 2]),
                .clr_i    (ctrl_clr[n]),
                .active_o (pin_active[n]),
                .edge_o   (pin_edge[n]),
                .latch_o  (pin_latch[n])
            );
        end
    endgenerate

    // Apply per-pin and master enables.
    assign gated = pin_active & ctrl_en & {N{ctrl_master}};

    // Steer pin 0 by the route bit; other pins always take the normal path.
    assign req_crit_o = gated[0] & ctrl_route;
    assign req_o      = {gated[N-1:1], gated[0] & ~ctrl_route};
endmodule

// File: rtl/xirq_checker.sv
// Module: assertion checker bound to xirq_conditioner. Observes ports and
// the internal control fields and latch/edge signals of the top module.
module xirq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rd_data,
    input logic [3:0]  req_o,
    input logic        req_crit_o,
    input logic        ctrl_master,
    input logic        ctrl_route,
    input logic [3:0]  ctrl_en,
    input logic [3:0]  ctrl_clr,
    input logic [3:0]  pin_edge,
    input logic [3:0]  pin_latch
);
    // R4: master off silences every output.
    a_r4_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_master |-> (req_o == 4'b0 && !req_crit_o));

    // R6: pin 0 never appears on both paths at once.
    a_r6_route_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_crit_o && req_o[0]));

    // R6: route bit clear keeps the critical output low.
    a_r6_crit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_route |-> !req_crit_o);

    // R3: clear bits never read back as 1.
    a_r3_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[27:24] == 4'b0);

    // R5: a disabled pin 0 drives neither output.
    a_r5_pin0_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en[0] |-> (!req_o[0] && !req_crit_o));

    genvar n;
    generate
        for (n = 1; n < 4; n++) begin : g_mask
            // R5: a disabled pin is masked.
            a_r5_pin_mask: assert property (@(posedge clk) disable iff (!rst_n)
                !ctrl_en[n] |-> !req_o[n]);
        end
        for (n = 0; n < 4; n++) begin : g_latch
            // R7: a latch only rises after an edge event.
            a_r7_latch_cause: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pin_latch[n]) |-> $past(pin_edge[n]));
            // R8: a latch only falls when its own clear was written.
            a_r8_latch_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pin_latch[n]) |-> $past(ctrl_clr[n]));
            // R10: an edge event always leaves the latch set.
            a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
                pin_edge[n] |=> pin_latch[n]);
        end
    endgenerate
endmodule

bind xirq_conditioner xirq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rd_data (cfg_rd_data),
    .req_o       (req_o),
    .req_crit_o  (req_crit_o),
    .ctrl_master (ctrl_master),
    .ctrl_route  (ctrl_route),
    .ctrl_en     (ctrl_en),
    .ctrl_clr    (ctrl_clr),
    .pin_edge    (pin_edge),
    .pin_latch   (pin_latch)
);

// File: tb/sim_xirq_conditioner.sv
// Bench: behavioural reference model compared with the design every cycle.
module sim_xirq_conditioner;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_i = 4'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = 32'b0;
    logic [31:0] cfg_rd_data;
    logic [3:0]  req_o;
    logic        req_crit_o;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Model state: pin sample history, stored fields, latches.
    bit [3:0]  h1, h2, h3;
    bit [31:0] m_ctrl;
    bit [3:0]  m_lat;

    xirq_conditioner u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin_i),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .req_o       (req_o),
        .req_crit_o  (req_crit_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Advance the reference model at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0; m_ctrl = 0; m_lat = 0;
        end else begin
            for (int n = 0; n < 4; n++) begin
                int  s;
                bit  ev;
                s  = (m_ctrl >> (22 - 2*n)) & 3;
                ev = (s == 1 && h2[n] && !h3[n]) || (s == 2 && !h2[n] && h3[n]);
                m_lat[n] = ev || (m_lat[n] && !(cfg_wr_en && cfg_wr_data[27-n]));
            end
            h3 = h2; h2 = h1; h1 = pin_i;
            if (cfg_wr_en) m_ctrl = cfg_wr_data & 32'h00FF1F01;
        end
    end

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            bit [3:0] g, exp_req;
            bit       exp_crit;
            for (int n = 0; n < 4; n++) begin
                int s;
                bit act;
                s = (m_ctrl >> (22 - 2*n)) & 3;
                act = (s == 0) ? h2[n] : (s == 3) ? !h2[n] : m_lat[n];
                g[n] = act && m_ctrl[11-n] && m_ctrl[12];
            end
            exp_crit = g[0] && m_ctrl[0];
            exp_req  = {g[3:1], g[0] && !m_ctrl[0]};
            checks++;
            if (req_o !== exp_req || req_crit_o !== exp_crit || cfg_rd_data !== m_ctrl) begin
                failures++;
                $display("FAIL %s t=%0t req=%b crit=%b rd=%h expected req=%b crit=%b rd=%h",
                         cur_req, $time, req_o, req_crit_o, cfg_rd_data,
                         exp_req, exp_crit, m_ctrl);
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_cyc(input int k);
        repeat (k) @(posedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0; cfg_wr_data = 32'b0;
    endtask

    task automatic set_pins(input logic [3:0] v);
        @(posedge clk); #1;
        pin_i = v;
    endtask

    initial begin
        // R1: reset state.
        cur_req = "R1";
        wait_cyc(3);
        #1 rst_n = 1'b1;
        wait_cyc(3);

        // R9: readback of stored fields only.
        cur_req = "R9";
        wr(32'hFFFF_FFFF);
        wait_cyc(2);
        wr(32'h0000_0000);

        // R2: level active high, then active low.
        cur_req = "R2";
        wr(32'h0000_1F00);
        for (int i = 0; i < 8; i++) begin
            set_pins(4'(i * 5));
            wait_cyc(3);
        end
        wr(32'h00FF_1F00);
        for (int i = 0; i < 8; i++) begin
            set_pins(4'(i * 3));
            wait_cyc(3);
        end
        set_pins(4'b0000);
        wait_cyc(3);

        // R7: rising edges latch and hold.
        cur_req = "R7";
        wr(32'h0055_1F00);
        set_pins(4'b0101);
        set_pins(4'b0000);
        wait_cyc(6);
        set_pins(4'b1010);
        wait_cyc(6);

        // R3: zero clear bits leave latches; clear bits read 0.
        cur_req = "R3";
        wr(32'h0055_1F00);
        wait_cyc(2);

        // R8: clear pin 2 alone, then pin 0 alone.
        cur_req = "R8";
        wr(32'h0255_1F00);
        wait_cyc(2);
        wr(32'h0855_1F00);
        wait_cyc(2);

        // R4: master off hides live latches, on exposes them.
        cur_req = "R4";
        wr(32'h0055_0F00);
        wait_cyc(3);
        wr(32'h0055_1F00);
        wait_cyc(2);

        // R5: per-pin enables.
        cur_req = "R5";
        wr(32'h0055_1A00);
        wait_cyc(2);
        wr(32'h0055_1500);
        wait_cyc(2);

        // R3: clear all latches.
        cur_req = "R3";
        wr(32'h0F55_1F00);
        wait_cyc(2);

        // R7: falling edges.
        cur_req = "R7";
        wr(32'h00AA_1F00);
        set_pins(4'b1111);
        wait_cyc(4);
        set_pins(4'b0110);
        wait_cyc(6);
        wr(32'h0FAA_1F00);
        wait_cyc(2);

        // R10: clear lands in the same cycle as a new rising edge on pin 1.
        cur_req = "R10";
        wr(32'h0055_1F00);
        set_pins(4'b0000);
        wait_cyc(4);
        @(posedge clk); #1 pin_i = 4'b0010;
        @(posedge clk);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_wr_data = 32'h0455_1F00;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0; cfg_wr_data = 32'b0;
        wait_cyc(3);

        // R6: route pin 0 to the critical output and back.
        cur_req = "R6";
        wr(32'h0F00_1F01);
        set_pins(4'b0001);
        wait_cyc(4);
        wr(32'h0000_1F00);
        wait_cyc(3);
        set_pins(4'b0000);
        wait_cyc(3);

        // R7: random pins and configuration writes.
        cur_req = "R7";
        for (int i = 0; i < 400; i++) begin
            set_pins(4'($urandom));
            if (($urandom % 8) == 0) wr($urandom);
        end
        wait_cyc(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule